// File: doc/BRIEF.md
# Packet And Word Token Rate Limiter

This block shapes the traffic of one output port with a debt-style token bucket. Software loads three values through a small write port: a fixed cost charged once per packet, a cost charged for every 8-byte word of the packet, and a burst limit. The limit is kept in coarse units of 256 tokens, so the debt threshold is the limit shifted left by 8 bits. Setting the word cost to zero gives a packets-per-second limiter. A bit-rate limiter charges 64 bits' worth of tokens per word, plus a per-packet cost that covers 24 bytes of line overhead: interframe gap, preamble and CRC.

When a packet is about to start, the requester presents its length in words. One cycle later the block answers with allow or stall. An allowed packet adds its full charge to the debt level. Every clock cycle the level drains by a fixed refill amount of 16 tokens, and it never drops below zero. Any configuration write clears the level. An active-low reset clears the level and all three configuration values. The reset is applied asynchronously and released in step with the clock.

Top module: `rate_token_shaper`

## Requirements
- R1: While reset is active, and after it is released, the level, the response valid and the allow output are all zero, and all three configuration values are zero.
- R2: The charge of a packet is the packet cost plus the word cost times the packet length in words. When the packet is allowed, the level at the next edge is max(level - 16, 0) plus this charge.
- R3: In a cycle with no allowed packet and no configuration write, the level drops by 16 tokens, and it stops at zero rather than wrapping.
- R4: A request is allowed when the current level is less than or equal to the limit times 256. The answer appears one cycle after the request, with response valid high and allow set to the decision.
- R5: A stalled request adds nothing to the level.
- R6: An allowed packet's full charge is added even if this takes the level above the threshold.
- R7: A configuration write loads the selected value: select 0 loads the packet cost, 1 loads the word cost, 2 loads the limit, and 3 loads nothing. Every write, including select 3, sets the level to zero at the next edge. A packet requested in the same cycle still gets its answer, but its charge is discarded.
- R8: Response valid is high only in the cycle right after a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration value select |
| cfg_data_i | input | CFG_W | Configuration write data |
| pkt_valid_i | input | 1 | Packet start request |
| pkt_words_i | input | LEN_W | Packet length in 8-byte words |
| resp_valid_o | output | 1 | Answer to the previous cycle's request |
| resp_allow_o | output | 1 | High when that request was allowed |
| level_o | output | ACC_W | Current debt level in tokens |

## Verification
The bench targets the threshold boundary. A level exactly equal to limit times 256 must be allowed; a design using a strict compare would stall it. The bench checks the overshoot after that allowed packet, and that a later stalled request is not charged. A design that clamps at the threshold, or charges stalled packets, would show a wrong level. The bench drains the level down to zero and waits there; a design with unsigned wrap would jump to a huge value. It also checks the same-cycle clash of a write and a request, a spare-select write that must clear the level without changing any cost, and a reset mid-run that must erase the configuration.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [1:0] {
    CFG_PKT_COST  = 2'd0,
    CFG_WORD_COST = 2'd1,
    CFG_BURST     = 2'd2,
    CFG_SPARE     = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/rts_reset_sync.sv
module rts_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/rts_cfg_regs.sv
module rts_cfg_regs
  import rts_pkg::*;
#(
  parameter int CFG_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [CFG_W-1:0] data_i,
  output logic [CFG_W-1:0] pkt_cost_o,
  output logic [CFG_W-1:0] word_cost_o,
  output logic [CFG_W-1:0] limit_o
);
  logic [CFG_W-1:0] pkt_q, word_q, lim_q;
  logic [CFG_W-1:0] pkt_d, word_d, lim_d;
  logic             pkt_en, word_en, lim_en;
  cfg_sel_e         sel;

  always_comb begin
    sel     = cfg_sel_e'(sel_i);
    pkt_en  = we_i && (sel == CFG_PKT_COST);
    word_en = we_i && (sel == CFG_WORD_COST);
    lim_en  = we_i && (sel == CFG_BURST);
    pkt_d   = pkt_en  ? data_i : pkt_q;
    word_d  = word_en ? data_i : word_q;
    lim_d   = lim_en  ? data_i : lim_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_q  <= '0;
      word_q <= '0;
      lim_q  <= '0;
    end else begin
      pkt_q  <= pkt_d;
      word_q <= word_d;
      lim_q  <= lim_d;
    end
  end

  assign pkt_cost_o  = pkt_q;
  assign word_cost_o = word_q;
  assign limit_o     = lim_q;

  // R7: a write to the spare select leaves every stored value untouched
  a_r7_spare_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 2'd3) |=> ($stable(pkt_q) && $stable(word_q) && $stable(lim_q)));
endmodule

// File: rtl/rts_charge_calc.sv
module rts_charge_calc #(
  parameter int CFG_W = 20,
  parameter int LEN_W = 12,
  localparam int CHG_W = CFG_W + LEN_W + 1
) (
  input  logic [CFG_W-1:0] pkt_cost_i,
  input  logic [CFG_W-1:0] word_cost_i,
  input  logic [LEN_W-1:0] words_i,
  output logic [CHG_W-1:0] charge_o
);
  logic [CHG_W-1:0] word_part;

  always_comb begin
    word_part = CHG_W'(word_cost_i) * CHG_W'(words_i);
    charge_o  = word_part + CHG_W'(pkt_cost_i);
  end
endmodule

// File: rtl/rts_bucket.sv
module rts_bucket #(
  parameter int CFG_W  = 20,
  parameter int CHG_W  = 33,
  parameter int ACC_W  = 40,
  parameter int REFILL = 16,
  localparam int THR_W = CFG_W + 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             clr_i,
  input  logic [CHG_W-1:0] charge_i,
  input  logic [CFG_W-1:0] limit_i,
  output logic             allow_o,
  output logic [ACC_W-1:0] level_o
);
  logic [ACC_W-1:0] level_q, level_d, drained;
  logic [THR_W-1:0] thresh;
  logic [ACC_W:0]   sum;
  logic             fire;

  always_comb begin
    thresh  = {limit_i, 8'h00};
    allow_o = (level_q <= ACC_W'(thresh));
    fire    = req_i && allow_o;
    drained = (level_q > ACC_W'(REFILL)) ? (level_q - ACC_W'(REFILL)) : '0;
    sum     = {1'b0, drained} + (fire ? (ACC_W+1)'(charge_i) : '0);
    if (clr_i)             level_d = '0;
    else if (sum[ACC_W])   level_d = '1;
    else                   level_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= level_d;
  end

  assign level_o = level_q;

  // R7: any configuration write empties the bucket
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (level_q == '0));
  // R5: without an allowed packet the level never grows
  a_r5_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire && !clr_i) |=> (level_q <= $past(level_q)));
  // R3: draining removes at most the refill amount per cycle
  a_r3_drain_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire && !clr_i) |=> (($past(level_q) - level_q) <= ACC_W'(REFILL)));
  // R6: an allowed packet leaves at least its charge in the bucket
  a_r6_full_charge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !clr_i) |=> (level_q >= ACC_W'($past(charge_i))));
endmodule

// File: rtl/rate_token_shaper.sv
module rate_token_shaper #(
  parameter int CFG_W  = 20,
  parameter int LEN_W  = 12,
  parameter int ACC_W  = 40,
  parameter int REFILL = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  input  logic             pkt_valid_i,
  input  logic [LEN_W-1:0] pkt_words_i,
  output logic             resp_valid_o,
  output logic             resp_allow_o,
  output logic [ACC_W-1:0] level_o
);
  localparam int CHG_W = CFG_W + LEN_W + 1;

  logic             rst_n;
  logic [CFG_W-1:0] pkt_cost, word_cost, limit;
  logic [CHG_W-1:0] charge;
  logic             allow;
  logic             rv_q, ra_q, rv_d, ra_d;

  rts_reset_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n));

  rts_cfg_regs #(.CFG_W(CFG_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_n), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .data_i(cfg_data_i), .pkt_cost_o(pkt_cost), .word_cost_o(word_cost),
    .limit_o(limit));

  rts_charge_calc #(.CFG_W(CFG_W), .LEN_W(LEN_W)) u_chg (
    .pkt_cost_i(pkt_cost), .word_cost_i(word_cost), .words_i(pkt_words_i),
    .charge_o(charge));

  rts_bucket #(.CFG_W(CFG_W), .CHG_W(CHG_W), .ACC_W(ACC_W), .REFILL(REFILL)) u_bkt (
    .clk_i(clk_i), .rst_ni(rst_n), .req_i(pkt_valid_i), .clr_i(cfg_we_i),
    .charge_i(charge), .limit_i(limit), .allow_o(allow), .level_o(level_o));

  always_comb begin
    rv_d = pkt_valid_i;
    ra_d = pkt_valid_i && allow;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      ra_q <= 1'b0;
    end else begin
      rv_q <= rv_d;
      ra_q <= ra_d;
    end
  end

  assign resp_valid_o = rv_q;
  assign resp_allow_o = ra_q;

  // R8: an answer only follows a request
  a_r8_resp_after_req: assert property (@(posedge clk_i) disable iff (!rst_n)
    resp_valid_o |-> $past(pkt_valid_i));
  // R4: allow is only reported together with a valid answer
  a_r4_allow_in_resp: assert property (@(posedge clk_i) disable iff (!rst_n)
    resp_allow_o |-> resp_valid_o);
endmodule

// File: tb/rate_token_shaper_tb.sv
module rate_token_shaper_tb_top;
  localparam int CLK_P  = 10;
  localparam int CFG_W  = 20;
  localparam int LEN_W  = 12;
  localparam int ACC_W  = 40;
  localparam int REFILL = 16;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             cfg_we;
  logic [1:0]       cfg_sel;
  logic [CFG_W-1:0] cfg_data;
  logic             pkt_valid;
  logic [LEN_W-1:0] pkt_words;
  logic             resp_valid, resp_allow;
  logic [ACC_W-1:0] level;

  int total = 0;
  int bad = 0;
  bit done = 0;
  longint exp_level = 0;
  longint sh_pkt = 0, sh_word = 0, sh_lim = 0;

  always #(CLK_P/2) clk = ~clk;

  rate_token_shaper #(.CFG_W(CFG_W), .LEN_W(LEN_W), .ACC_W(ACC_W), .REFILL(REFILL)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_data_i(cfg_data), .pkt_valid_i(pkt_valid), .pkt_words_i(pkt_words),
    .resp_valid_o(resp_valid), .resp_allow_o(resp_allow), .level_o(level));

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock cycle of stimulus, with the expected result computed from the requirements
  task automatic cycle(input bit pv, input int words, input bit we, input int sel,
                       input int data, input string tag);
    longint thr, fl, chg;
    bit alw;
    thr = sh_lim * 256;
    alw = (exp_level <= thr);
    chg = sh_pkt + sh_word * words;
    fl  = (exp_level > REFILL) ? exp_level - REFILL : 0;
    pkt_valid = pv; pkt_words = LEN_W'(words);
    cfg_we = we; cfg_sel = 2'(sel); cfg_data = CFG_W'(data);
    @(posedge clk); #1;
    pkt_valid = 1'b0; cfg_we = 1'b0;
    if (we) begin
      exp_level = 0;
      case (sel)
        0: sh_pkt = data;
        1: sh_word = data;
        2: sh_lim = data;
        default: ;
      endcase
    end else if (pv && alw) exp_level = fl + chg;
    else exp_level = fl;
    check({tag, " R8 resp_valid"}, longint'(resp_valid), longint'(pv));
    check({tag, " R4 allow"}, longint'(resp_allow), longint'(pv && alw));
    check({tag, " level"}, longint'(level), exp_level);
  endtask

  task automatic idle(input string tag);
    cycle(0, 0, 0, 0, 0, tag);
  endtask

  task automatic write_cfg(input int sel, input int data);
    cycle(0, 0, 1, sel, data, "R7 cfg write");
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    check("R1 level in reset", longint'(level), 0);
    check("R1 resp_valid in reset", longint'(resp_valid), 0);
    check("R1 allow in reset", longint'(resp_allow), 0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    exp_level = 0; sh_pkt = 0; sh_word = 0; sh_lim = 0;
    check("R1 level after reset", longint'(level), 0);
  endtask

  task automatic t_packet_rate();
    write_cfg(0, 100); write_cfg(1, 0); write_cfg(2, 1);
    cycle(1, 7, 0, 0, 0, "R2 pkt-only first");
    check("R2 word cost zero", longint'(level), 100);
    idle("R3 drain");
    cycle(1, 3, 0, 0, 0, "R2 pkt-only second");
    cycle(1, 9, 0, 0, 0, "R2 pkt-only third");
    cycle(1, 1, 0, 0, 0, "R6 pkt-only fourth");
    check("R6 level above threshold", longint'(level), 336);
    cycle(1, 1, 0, 0, 0, "R5 stalled");
    check("R5 stall not charged", longint'(level), 320);
  endtask

  task automatic t_boundary();
    write_cfg(0, 272); write_cfg(1, 0); write_cfg(2, 1);
    cycle(1, 0, 0, 0, 0, "R2 boundary load");
    idle("R3 boundary drain");
    check("R4 level at threshold", longint'(level), 256);
    cycle(1, 0, 0, 0, 0, "R4 equal allowed");
    check("R6 overshoot", longint'(level), 512);
    cycle(1, 0, 0, 0, 0, "R5 over threshold");
    check("R5 stall level", longint'(level), 496);
  endtask

  task automatic t_words();
    write_cfg(0, 192); write_cfg(1, 64); write_cfg(2, 4);
    cycle(1, 5, 0, 0, 0, "R2 five words");
    check("R2 charge with words", longint'(level), 512);
    cycle(1, 0, 0, 0, 0, "R2 zero words");
    check("R2 packet cost only", longint'(level), 688);
  endtask

  task automatic t_drain();
    write_cfg(0, 20); write_cfg(1, 0); write_cfg(2, 1);
    cycle(1, 0, 0, 0, 0, "R3 small load");
    idle("R3 drain to 4");
    idle("R3 drain to zero");
    check("R3 floor at zero", longint'(level), 0);
    idle("R3 stay zero");
    check("R3 no wrap", longint'(level), 0);
  endtask

  task automatic t_cfg_clash();
    write_cfg(0, 300); write_cfg(1, 2); write_cfg(2, 2);
    cycle(1, 10, 0, 0, 0, "R2 clash preload");
    cycle(1, 10, 1, 0, 50, "R7 write with request");
    check("R7 charge discarded", longint'(level), 0);
    cycle(1, 10, 0, 0, 0, "R7 new pkt cost");
    check("R7 new cost used", longint'(level), 70);
    cycle(0, 0, 1, 3, 999, "R7 spare select");
    check("R7 spare clears level", longint'(level), 0);
    cycle(1, 10, 0, 0, 0, "R7 costs kept");
    check("R7 spare leaves costs", longint'(level), 70);
  endtask

  task automatic t_reset_mid();
    write_cfg(0, 500); write_cfg(2, 0);
    cycle(1, 4, 0, 0, 0, "R2 pre-reset load");
    do_reset();
    cycle(1, 4, 0, 0, 0, "R1 config cleared");
    check("R1 zero costs after reset", longint'(level), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cfg_we = 1'b0; cfg_sel = 2'd0; cfg_data = '0;
    pkt_valid = 1'b0; pkt_words = '0;
    do_reset();
    idle("R8 idle after reset");
    t_packet_rate();
    t_boundary();
    t_words();
    t_drain();
    t_cfg_clash();
    t_reset_mid();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule